// File: doc/BRIEF.md
# Clock Frequency Monitor

This block decides, window by window, whether a monitored clock is running fast enough. A free-running reference clock marks out fixed windows of `WIN_LEN` reference cycles. Over the same span the monitored clock counts its own rising edges. At the end of each window the count is brought across to the reference side, where it is compared against a minimum edge count given on an input. A short count, or a count that never comes back because the monitored clock has stopped, is a failing window.

The result drives an active-low error pin, `err_n`, which the reset and interrupt logic of the chip can take. The monitor is held off while reset is asserted and is armed when reset ends, as long as `enable` is high. When the frequency recovers, the pin is not released at once. A small counter on the monitored clock holds the error low for 16 to 32 monitored cycles after the last failing verdict has crossed over, and only then lets the pin go high.

Top module: `freq_watch`

## Requirements
- R1: While `rst_n` is low, `err_n` is high from the first reference edge that samples `rst_n` low onwards, whatever the state of the monitored clock.
- R2: Once `rst_n` goes high with `enable` high, the monitor is armed. `err_n` stays high until the first window of `WIN_LEN` reference cycles has been judged. If that first window fails, `err_n` goes low as soon as the verdict is reached, with no further windows needed.
- R3: A window passes when the number of rising edges of `mon_clk` counted in it is at least `min_edges`, and fails when it is smaller. While failing verdicts persist, `err_n` stays low.
- R4: If a window ends while the count of the previous window has still not been returned by the monitored side, that window is a fail. A stopped `mon_clk` therefore drives `err_n` low. A count that arrives late is discarded, and the error clears only after a later complete window passes.
- R5: After the first passing verdict that follows a failure, `err_n` stays low for at least 16 further `mon_clk` cycles. It goes high within 32 monitored cycles plus the synchronizer latency.
- R6: With `enable` low, `err_n` is high from the next reference edge onwards, and failing windows have no effect on it. Raising `enable` again re-arms the monitor.
- R7: Asserting `rst_n` in the middle of a failure releases `err_n` at once. After reset ends, the monitor starts over with a fresh first window, as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference time base that sets the judging windows |
| mon_clk | input | 1 | Clock whose frequency is being watched |
| rst_n | input | 1 | Synchronous active-low reset from the reset controller, sampled in both clock domains |
| enable | input | 1 | Arms the monitor when high (reference domain) |
| min_edges | input | CNT_W | Smallest edge count per window that counts as a pass |
| err_n | output | 1 | Active-low frequency error |

## Verification
The assertions take for granted three things about the inputs. First, `rst_n` is held low for long enough to be seen by at least two edges of each clock. Second, `min_edges` changes only slowly compared with a window. Third, `mon_clk` either toggles cleanly or stops; it never glitches. The stimulus changes `min_edges` and the monitored period only at reference falling edges, and then waits several windows before judging. It keeps the monitored clock running through every reset pulse. It chooses threshold and period pairs whose ideal edge count lies at least three edges away from the threshold, so that the one-edge uncertainty at window boundaries cannot flip a verdict.

// File: rtl/fw_pkg.sv
package fw_pkg;

    // Outcome of one reference-side judging step.
    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,  // nothing decided this cycle
        VERD_PASS  = 2'd1,  // fresh count at or above the threshold
        VERD_SHORT = 2'd2,  // fresh count below the threshold
        VERD_STALL = 2'd3   // window ended with the previous count still outstanding
    } verdict_e;

    // True when a verdict marks the clock as too slow.
    function automatic logic is_fail(input verdict_e v);
        return (v == VERD_SHORT) || (v == VERD_STALL);
    endfunction

endpackage

// File: rtl/fw_sync.sv
// fw_sync: multi-stage flop synchronizer for a single level or toggle bit.
// Assumes the input is quasi-static relative to the destination clock
// (it is a level or a toggle that changes at most once per several cycles).
module fw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the input through the synchronizing stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fw_edge_counter.sv
// fw_edge_counter: monitored-domain edge counter with toggle-handshake capture.
// Counts mon_clk rising edges since the last capture. A change on the
// synchronized request toggle copies the running count into a hold register
// and flips the acknowledge toggle. Assumes the hold register is read by the
// other domain only after the acknowledge has been synchronized there.
module fw_edge_counter #(
    parameter int CNT_W = 10
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    input  logic             req_s,
    output logic             ack_t,
    output logic [CNT_W-1:0] hold_cnt
);

    logic [CNT_W-1:0] run_cnt;
    logic             req_q;
    logic             take;

    assign take = req_s ^ req_q;

    // Remember the request toggle to detect a new request.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_s;
        end
    end

    // Saturating edge count; the capture edge itself opens the next span.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (take) begin
            run_cnt <= CNT_W'(1);
        end else if (run_cnt != {CNT_W{1'b1}}) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Freeze the finished span's count and acknowledge the request.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            ack_t    <= 1'b0;
        end else if (take) begin
            hold_cnt <= run_cnt;
            ack_t    <= ~ack_t;
        end
    end

endmodule

// File: rtl/fw_window_judge.sv
// fw_window_judge: reference-domain window timer, request issuer and verdict.
// Every WIN_LEN reference cycles it asks the monitored side for its count.
// If the previous request is still unanswered at that point, the window fails.
// An answer is trusted only if it belongs to a request that was issued on
// time. Assumes hold_cnt is stable whenever ack_s has just changed.
module fw_window_judge
    import fw_pkg::*;
#(
    parameter int WIN_LEN = 64,
    parameter int CNT_W   = 10
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] min_edges,
    input  logic [CNT_W-1:0] hold_cnt,
    input  logic             ack_s,
    output logic             req_t,
    output logic             win_last,
    output logic             pending,
    output logic             arm_q,
    output logic             fail_r
);

    localparam int WIN_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [WIN_W-1:0] WIN_TOP = WIN_W'(WIN_LEN - 1);

    logic [WIN_W-1:0] win_cnt;
    logic             ack_q;
    logic             fresh;
    logic             arrive;
    verdict_e         verdict;

    assign win_last = (win_cnt == WIN_TOP);
    assign pending  = req_t ^ ack_s;
    assign arrive   = ack_s ^ ack_q;

    // Free-running window timer.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (win_last) begin
            win_cnt <= '0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // Issue a request at each window end, or mark the outstanding one as stale.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            req_t <= 1'b0;
            fresh <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            ack_q <= ack_s;
            if (win_last) begin
                if (!pending) begin
                    req_t <= ~req_t;
                    fresh <= 1'b1;
                end else begin
                    fresh <= 1'b0;
                end
            end
        end
    end

    // Classify what happened this cycle.
    always_comb begin
        verdict = VERD_NONE;
        if (arrive && fresh) begin
            verdict = (hold_cnt < min_edges) ? VERD_SHORT : VERD_PASS;
        end else if (win_last && pending) begin
            verdict = VERD_STALL;
        end
    end

    // Arm flag follows enable; inhibited through reset.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else begin
            arm_q <= enable;
        end
    end

    // Sticky fail level, updated only on verdicts and cleared when disabled.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            fail_r <= 1'b0;
        end else if (!enable) begin
            fail_r <= 1'b0;
        end else if (verdict == VERD_PASS) begin
            fail_r <= 1'b0;
        end else if (is_fail(verdict)) begin
            fail_r <= 1'b1;
        end
    end

endmodule

// File: rtl/fw_release.sv
// fw_release: monitored-domain error hold with delayed release.
// While the synchronized fail level is high the error is set and the delay
// counter is cleared. After fail drops, the counter runs, and the error is
// released once its top bit sets (2**(REL_W-1) cycles plus one).
// Assumes fail_s is already synchronized to mon_clk.
module fw_release #(
    parameter int REL_W = 5
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic fail_s,
    output logic err_mon
);

    logic [REL_W-1:0] rel_cnt;

    // Restart on fail, count while holding, release when the top bit sets.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            rel_cnt <= '0;
            err_mon <= 1'b0;
        end else if (fail_s) begin
            rel_cnt <= '0;
            err_mon <= 1'b1;
        end else if (err_mon) begin
            if (rel_cnt[REL_W-1]) begin
                err_mon <= 1'b0;
            end else begin
                rel_cnt <= rel_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/freq_watch.sv
// freq_watch: clock frequency monitor with an active-low error output.
// Compares the edge count of mon_clk per reference window against min_edges.
// Assumes rst_n is held low for at least two edges of both clocks, and that
// min_edges changes rarely compared with a window.
module freq_watch #(
    parameter int WIN_LEN     = 64,
    parameter int CNT_W       = 10,
    parameter int REL_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             mon_clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] min_edges,
    output logic             err_n
);

    logic             req_t;
    logic             req_s;
    logic             ack_t;
    logic             ack_s;
    logic [CNT_W-1:0] hold_cnt;
    logic             win_last;
    logic             pending;
    logic             arm_q;
    logic             fail_r;
    logic             fail_s;
    logic             err_mon;

    fw_window_judge #(
        .WIN_LEN (WIN_LEN),
        .CNT_W   (CNT_W)
    ) u_judge (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .min_edges (min_edges),
        .hold_cnt  (hold_cnt),
        .ack_s     (ack_s),
        .req_t     (req_t),
        .win_last  (win_last),
        .pending   (pending),
        .arm_q     (arm_q),
        .fail_r    (fail_r)
    );

    fw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (mon_clk),
        .rst_n (rst_n),
        .d     (req_t),
        .q     (req_s)
    );

    fw_edge_counter #(.CNT_W(CNT_W)) u_count (
        .mon_clk  (mon_clk),
        .rst_n    (rst_n),
        .req_s    (req_s),
        .ack_t    (ack_t),
        .hold_cnt (hold_cnt)
    );

    fw_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (ack_t),
        .q     (ack_s)
    );

    fw_sync #(.STAGES(SYNC_STAGES)) u_fail_sync (
        .clk   (mon_clk),
        .rst_n (rst_n),
        .d     (fail_r),
        .q     (fail_s)
    );

    fw_release #(.REL_W(REL_W)) u_release (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .fail_s  (fail_s),
        .err_mon (err_mon)
    );

    // Error is low while armed and either side still reports a failure.
    assign err_n = ~(arm_q & (fail_r | err_mon));

endmodule

// File: rtl/fw_checker.sv
// fw_checker: temporal properties of freq_watch, bound to every instance.
module fw_checker #(
    parameter int REL_W = 5
) (
    input logic ref_clk,
    input logic mon_clk,
    input logic rst_n,
    input logic enable,
    input logic err_n,
    input logic arm_q,
    input logic fail_r,
    input logic req_t,
    input logic win_last,
    input logic pending,
    input logic fail_s,
    input logic err_mon
);

    localparam int HOLD_MIN = 2 ** (REL_W - 1);

    logic [REL_W:0] gap_q;

    // Monitored cycles since the synchronized fail level was last high.
    always_ff @(posedge mon_clk) begin
        if (!rst_n || fail_s) begin
            gap_q <= '0;
        end else if (gap_q != {(REL_W+1){1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1: reset holds the error pin released
    assert_reset_quiet_R1: assert property (@(posedge ref_clk)
        !rst_n |=> err_n);

    // R6: disabling releases the pin on the next edge
    assert_disable_quiet_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !enable |=> err_n);

    // R6: a low pin always comes with an armed monitor
    assert_low_needs_arm_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !err_n |-> arm_q);

    // R3: new requests are only issued at a window boundary
    assert_req_at_boundary_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (req_t != $past(req_t)) |-> $past(win_last));

    // R4: an unanswered request at window end marks a failure
    assert_stall_fails_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (win_last && pending && enable) |=> fail_r);

    // R5: a synchronized fail sets the monitored-side hold
    assert_fail_sets_hold_R5: assert property (@(posedge mon_clk) disable iff (!rst_n)
        fail_s |=> err_mon);

    // R5: the hold never releases sooner than the minimum delay
    assert_min_hold_R5: assert property (@(posedge mon_clk) disable iff (!rst_n)
        $fell(err_mon) |-> (gap_q >= (REL_W+1)'(HOLD_MIN)));

endmodule

bind freq_watch fw_checker #(.REL_W(REL_W)) u_chk (
    .ref_clk  (ref_clk),
    .mon_clk  (mon_clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .err_n    (err_n),
    .arm_q    (arm_q),
    .fail_r   (fail_r),
    .req_t    (req_t),
    .win_last (win_last),
    .pending  (pending),
    .fail_s   (fail_s),
    .err_mon  (err_mon)
);

// File: tb/freq_watch_test.sv
`timescale 1ns/1ps
module freq_watch_test;

    localparam int WIN_LEN = 32;
    localparam int CNT_W   = 8;
    localparam real REF_PER = 5.0;
    localparam real WIN_NS  = WIN_LEN * REF_PER;

    logic             ref_clk = 1'b0;
    logic             mon_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic             enable  = 1'b1;
    logic [CNT_W-1:0] min_edges = CNT_W'(4);
    logic             err_n;

    real mon_half = 10.0;
    bit  mon_run  = 1'b1;
    bit  done     = 1'b0;
    int  n_chk    = 0;
    int  n_bad    = 0;

    freq_watch #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) uut (
        .ref_clk   (ref_clk),
        .mon_clk   (mon_clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .min_edges (min_edges),
        .err_n     (err_n)
    );

    always #2.5 ref_clk = ~ref_clk;

    always begin
        if (mon_run) #(mon_half) mon_clk = ~mon_clk;
        else #1.0;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: err_n actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    initial begin
        repeat (150000) @(posedge ref_clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        real halves [6] = '{1.0, 1.5, 2.5, 4.0, 6.0, 10.0};
        int  thrs   [8] = '{4, 10, 16, 24, 30, 40, 60, 90};
        bit  seen;

        // R1: slow clock with a high threshold, still quiet during reset
        min_edges = CNT_W'(40);
        cycles(20);
        check("R1 reset quiet", int'(err_n), 1);

        // R2: no verdict before the first window closes, then a fail at once
        rst_n = 1'b1;
        cycles(10);
        check("R2 before first verdict", int'(err_n), 1);
        cycles(60);
        check("R2 first window fails", int'(err_n), 0);

        // R3: sweep period and threshold; 160 ns window over the mon period
        foreach (halves[i]) begin
            foreach (thrs[j]) begin
                real expc;
                expc = WIN_NS / (2.0 * halves[i]);
                if ((expc - thrs[j] < 3.0) && (thrs[j] - expc < 3.0)) continue;
                mon_half  = halves[i];
                min_edges = CNT_W'(thrs[j]);
                cycles(500);
                check("R3 sweep", int'(err_n), (expc < real'(thrs[j])) ? 0 : 1);
            end
        end

        // R4: stopped clock raises the error, restart clears it
        mon_half  = 2.5;
        min_edges = CNT_W'(4);
        cycles(500);
        check("R4 running pass", int'(err_n), 1);
        mon_run = 1'b0;
        cycles(3 * WIN_LEN + 20);
        check("R4 stopped clock fails", int'(err_n), 0);
        cycles(200);
        check("R4 stays failed", int'(err_n), 0);
        mon_run = 1'b1;
        cycles(500);
        check("R4 recovers after restart", int'(err_n), 1);

        // R5: release delay of at least 16 monitored cycles (20 ns each)
        mon_half  = 10.0;
        min_edges = CNT_W'(20);
        cycles(500);
        check("R5 failing before recovery", int'(err_n), 0);
        min_edges = CNT_W'(4);
        cycles(64);
        check("R5 still held after 16 mon cycles", int'(err_n), 0);
        seen = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge ref_clk);
            if (err_n) begin
                seen = 1'b1;
                break;
            end
        end
        check("R5 released in bound", int'(seen), 1);

        // R6: disable forces release, re-enable re-arms
        min_edges = CNT_W'(20);
        cycles(500);
        check("R6 failing while enabled", int'(err_n), 0);
        enable = 1'b0;
        cycles(1);
        check("R6 released next edge", int'(err_n), 1);
        cycles(300);
        check("R6 fails ignored while disabled", int'(err_n), 1);
        enable = 1'b1;
        cycles(300);
        check("R6 re-armed", int'(err_n), 0);

        // R7: reset during a failure, then a fresh first window
        rst_n = 1'b0;
        cycles(2);
        check("R7 reset releases", int'(err_n), 1);
        cycles(18);
        rst_n = 1'b1;
        cycles(10);
        check("R7 fresh window pending", int'(err_n), 1);
        cycles(90);
        check("R7 fails again after reset", int'(err_n), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule